// File: doc/BRIEF.md
# USB Device Event Interrupt Vector Unit

This unit gathers single-cycle event strobes from a USB device engine into latched request bits. Each request bit has a matching enable bit. It drives one interrupt line to a processor and computes a vector address for the most urgent event that is both latched and enabled. There are nine event sources. Seven are general bus events: setup data available, start of frame, setup token, suspend, bus reset, high-speed entered and control handshake acknowledged. Two concern endpoint zero: the IN buffer is ready to load, and the OUT buffer holds data. Software reads and writes the enable and request registers through a small single-address register port. It acknowledges an event by writing a one to the event's request bit.

The vector is a fixed base plus a fixed step times the event's priority slot. The ten slots rank the seven bus events first. Slot 7 is reserved and never produced. The two endpoint-zero events take slots 8 and 9. When no enabled event is pending, the vector keeps its last value.

Top module: `uirq_vec_top`

## Requirements
- R1: After reset all four registers read zero, `irq_o` is low and `vec_o` equals the base 0x500.
- R2: An event strobe sets its request bit at the next clock edge even when its enable bit is zero, so the bit can be polled. Such a disabled request does not raise `irq_o`.
- R3: Writing to a request register clears exactly the bits written as one. Bits written as zero keep their value.
- R4: If an event strobe and a write-one-to-clear of the same bit fall in the same cycle, the bit ends up set.
- R5: `irq_o` is high in every cycle in which at least one request bit and its enable bit are both one, in either register pair, and low otherwise.
- R6: While an enabled event is pending, `vec_o` equals 0x500 + 4*slot for the highest-priority such event. Slots rank highest first: 0 setup data, 1 start of frame, 2 setup token, 3 suspend, 4 bus reset, 5 high-speed entered, 6 control ACK, 8 EP0-IN ready, 9 EP0-OUT data.
- R7: `vec_o` never takes the reserved value 0x51C. The EP0-IN event gives 0x520 and the EP0-OUT event gives 0x524.
- R8: While nothing enabled is pending, `vec_o` holds the value it had in the previous cycle.
- R9: Register addresses are 0 for the bus-event enables, 1 for the bus-event requests, 2 for the endpoint-zero enables and 3 for the endpoint-zero requests. The bus-event registers use bit0 setup data, bit1 SOF, bit2 setup token, bit3 suspend, bit4 bus reset, bit5 high-speed and bit6 control ACK, with bit7 reading 0. The endpoint-zero registers use bit0 IN ready and bit1 OUT data, with bits 7:2 reading 0. Any other address reads 0 and ignores writes.
- R10: A write to an enable register takes effect at the next clock edge and reads back as written, restricted to its defined bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_setup_data_i | input | 1 | Strobe: setup data available |
| ev_sof_i | input | 1 | Strobe: start of frame |
| ev_setup_tok_i | input | 1 | Strobe: setup token received |
| ev_suspend_i | input | 1 | Strobe: suspend requested |
| ev_bus_reset_i | input | 1 | Strobe: bus reset seen |
| ev_hispeed_i | input | 1 | Strobe: high-speed operation entered |
| ev_ctl_ack_i | input | 1 | Strobe: control handshake acknowledged |
| ev_ep0_in_i | input | 1 | Strobe: EP0-IN buffer ready to load |
| ev_ep0_out_i | input | 1 | Strobe: EP0-OUT buffer has data |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address for read and write |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, combinational from the address |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | VEC_W | Vector address of the most urgent enabled pending event |

## Verification
The bench builds the unit with its default parameters: a 4-bit address, 8-bit data, a 12-bit vector, base 0x500 and step 4. The 4-bit address leaves twelve unmapped addresses, so the bench can show that writes to them have no effect. The 12-bit vector holds every slot address, and the bench checks that the reserved code never appears in it. Dense random strobes that collide with clearing writes reach the case where a set and a clear hit the same bit. Sparse enables reach the case where the vector must hold its value while nothing enabled is pending.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

  localparam int BUS_SRC  = 7;
  localparam int EP0_SRC  = 2;
  localparam int RSV_SLOT = BUS_SRC;
  localparam int SLOT_CNT = BUS_SRC + 1 + EP0_SRC;
  localparam int SLOT_W   = $clog2(SLOT_CNT);

  // lowest-numbered set bit is the most urgent slot
  function automatic logic [SLOT_W-1:0] top_slot(input logic [SLOT_CNT-1:0] p);
    logic [SLOT_W-1:0] s;
    s = '0;
    for (int i = SLOT_CNT - 1; i >= 0; i--) begin
      if (p[i]) s = SLOT_W'(i);
    end
    return s;
  endfunction

  // vector address arithmetic: base plus step per slot
  function automatic int unsigned slot_addr(input int unsigned base,
                                            input int unsigned step,
                                            input int unsigned slot);
    return base + step * slot;
  endfunction

endpackage

// File: rtl/uirq_src_bank.sv
module uirq_src_bank #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         en_wr_i,
  input  logic         req_clr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] req_o,
  output logic [W-1:0] pend_o
);

  logic [W-1:0] en_q;
  logic [W-1:0] req_q;
  logic [W-1:0] clr_w;
  logic [W-1:0] req_nxt;

  assign clr_w   = req_clr_i ? wdata_i : '0;
  assign req_nxt = (req_q & ~clr_w) | set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      req_q <= '0;
    end else begin
      if (en_wr_i) en_q <= wdata_i;
      req_q <= req_nxt;
    end
  end

  assign en_o   = en_q;
  assign req_o  = req_q;
  assign pend_o = req_q & en_q;

  // every strobed bit is latched, whatever the clear asked for
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((req_q & $past(set_i)) == $past(set_i)));

  // bits cleared without a competing strobe end up low
  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_clr_i && ((wdata_i & ~set_i) != '0)) |=> ((req_q & $past(wdata_i & ~set_i)) == '0));

  // bits not written as one and not strobed keep their value
  assert_w1c_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_clr_i |=> ((req_q & ~$past(wdata_i)) == ($past(req_q) & ~$past(wdata_i) | $past(set_i) & ~$past(wdata_i))));

endmodule

// File: rtl/uirq_vec_enc.sv
module uirq_vec_enc
  import uirq_pkg::*;
#(
  parameter int          VEC_W    = 12,
  parameter int unsigned VEC_BASE = 32'h500,
  parameter int unsigned VEC_STEP = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SLOT_CNT-1:0] pend_i,
  output logic                any_o,
  output logic [VEC_W-1:0]    vec_o
);

  localparam logic [SLOT_CNT-1:0] RSV_MASK = SLOT_CNT'(1) << RSV_SLOT;

  logic [SLOT_CNT-1:0] eff_w;
  logic [SLOT_W-1:0]   slot_w;
  logic [SLOT_CNT-1:0] above_w;

  assign eff_w  = pend_i & ~RSV_MASK;
  assign any_o  = |eff_w;
  assign slot_w = top_slot(eff_w);
  assign vec_o  = VEC_W'(slot_addr(VEC_BASE, VEC_STEP, 32'(slot_w)));

  // slots more urgent than the chosen one
  assign above_w = (SLOT_CNT'(1) << slot_w) - SLOT_CNT'(1);

  assert_slot_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> eff_w[slot_w]);

  assert_slot_highest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> ((pend_i & above_w) == '0));

endmodule

// File: rtl/uirq_vec_top.sv
module uirq_vec_top
  import uirq_pkg::*;
#(
  parameter int          ADDR_W   = 4,
  parameter int          DATA_W   = 8,
  parameter int          VEC_W    = 12,
  parameter int unsigned VEC_BASE = 32'h500,
  parameter int unsigned VEC_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_setup_data_i,
  input  logic              ev_sof_i,
  input  logic              ev_setup_tok_i,
  input  logic              ev_suspend_i,
  input  logic              ev_bus_reset_i,
  input  logic              ev_hispeed_i,
  input  logic              ev_ctl_ack_i,
  input  logic              ev_ep0_in_i,
  input  logic              ev_ep0_out_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o
);

  localparam logic [ADDR_W-1:0] A_BUS_EN  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_BUS_REQ = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_EP0_EN  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_EP0_REQ = ADDR_W'(3);
  localparam logic [VEC_W-1:0]  RST_VEC   = VEC_W'(VEC_BASE);
  localparam logic [VEC_W-1:0]  RSV_VEC   = VEC_W'(slot_addr(VEC_BASE, VEC_STEP, RSV_SLOT));

  logic [BUS_SRC-1:0]  bus_set_w, bus_en_w, bus_req_w, bus_pend_w;
  logic [EP0_SRC-1:0]  ep0_set_w, ep0_en_w, ep0_req_w, ep0_pend_w;
  logic [SLOT_CNT-1:0] slots_w;
  logic                any_w;
  logic [VEC_W-1:0]    vec_comb_w;
  logic [VEC_W-1:0]    last_q;
  logic                unused_wdata;

  assign bus_set_w = {ev_ctl_ack_i, ev_hispeed_i, ev_bus_reset_i, ev_suspend_i,
                      ev_setup_tok_i, ev_sof_i, ev_setup_data_i};
  assign ep0_set_w = {ev_ep0_out_i, ev_ep0_in_i};
  assign unused_wdata = ^reg_wdata_i[DATA_W-1:BUS_SRC];

  uirq_src_bank #(.W(BUS_SRC)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (bus_set_w),
    .en_wr_i   (reg_wr_i && reg_addr_i == A_BUS_EN),
    .req_clr_i (reg_wr_i && reg_addr_i == A_BUS_REQ),
    .wdata_i   (reg_wdata_i[BUS_SRC-1:0]),
    .en_o      (bus_en_w),
    .req_o     (bus_req_w),
    .pend_o    (bus_pend_w)
  );

  uirq_src_bank #(.W(EP0_SRC)) u_ep0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (ep0_set_w),
    .en_wr_i   (reg_wr_i && reg_addr_i == A_EP0_EN),
    .req_clr_i (reg_wr_i && reg_addr_i == A_EP0_REQ),
    .wdata_i   (reg_wdata_i[EP0_SRC-1:0]),
    .en_o      (ep0_en_w),
    .req_o     (ep0_req_w),
    .pend_o    (ep0_pend_w)
  );

  assign slots_w = {ep0_pend_w, 1'b0, bus_pend_w};

  uirq_vec_enc #(
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
  ) u_enc (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend_i (slots_w),
    .any_o  (any_w),
    .vec_o  (vec_comb_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     last_q <= RST_VEC;
    else if (any_w) last_q <= vec_comb_w;
  end

  assign vec_o = any_w ? vec_comb_w : last_q;
  assign irq_o = any_w;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_BUS_EN:  reg_rdata_o = DATA_W'(bus_en_w);
      A_BUS_REQ: reg_rdata_o = DATA_W'(bus_req_w);
      A_EP0_EN:  reg_rdata_o = DATA_W'(ep0_en_w);
      A_EP0_REQ: reg_rdata_o = DATA_W'(ep0_req_w);
      default:   reg_rdata_o = '0;
    endcase
  end

  assert_no_rsv_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_o != RSV_VEC);

  assert_vec_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (vec_o == $past(vec_o)));

  assert_irq_follows_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_req_w & bus_en_w) == '0 && (ep0_req_w & ep0_en_w) == '0) |-> !irq_o);

endmodule

// File: tb/uirq_vec_top_test.sv
`timescale 1ns/1ps
module uirq_vec_top_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  ev = '0;
  logic        wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;
  logic [11:0] vec;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [6:0]  m_bus_en, m_bus_req;
  logic [1:0]  m_ep0_en, m_ep0_req;
  logic [11:0] m_last;

  always #2.5 clk = ~clk;

  uirq_vec_top uut (
    .clk             (clk),
    .rst_n           (rst_n),
    .ev_setup_data_i (ev[0]),
    .ev_sof_i        (ev[1]),
    .ev_setup_tok_i  (ev[2]),
    .ev_suspend_i    (ev[3]),
    .ev_bus_reset_i  (ev[4]),
    .ev_hispeed_i    (ev[5]),
    .ev_ctl_ack_i    (ev[6]),
    .ev_ep0_in_i     (ev[7]),
    .ev_ep0_out_i    (ev[8]),
    .reg_wr_i        (wr),
    .reg_addr_i      (addr),
    .reg_wdata_i     (wdata),
    .reg_rdata_o     (rdata),
    .irq_o           (irq),
    .vec_o           (vec)
  );

  function automatic bit m_any();
    return ((m_bus_req & m_bus_en) != 0) || ((m_ep0_req & m_ep0_en) != 0);
  endfunction

  // urgency list written out: slot index -> pending flag
  function automatic logic [11:0] m_vec();
    logic [9:0] p;
    p = {m_ep0_req & m_ep0_en, 1'b0, m_bus_req & m_bus_en};
    for (int s = 0; s < 10; s++) begin
      if (p[s]) return 12'h500 + 12'(s << 2);
    end
    return m_last;
  endfunction

  function automatic logic [7:0] m_read(input logic [3:0] a);
    case (a)
      4'd0: return {1'b0, m_bus_en};
      4'd1: return {1'b0, m_bus_req};
      4'd2: return {6'b0, m_ep0_en};
      4'd3: return {6'b0, m_ep0_req};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // called at a negedge: drive, clock, update model, check at next negedge
  task automatic cycle(input logic [8:0] e, input logic w, input logic [3:0] a,
                       input logic [7:0] d, input string tag);
    logic [6:0] bclr;
    logic [1:0] eclr;
    ev = e; wr = w; addr = a; wdata = d;
    @(posedge clk);
    #1;
    if (m_any()) m_last = m_vec();
    bclr = (w && a == 4'd1) ? d[6:0] : 7'd0;
    eclr = (w && a == 4'd3) ? d[1:0] : 2'd0;
    m_bus_req = (m_bus_req & ~bclr) | e[6:0];
    m_ep0_req = (m_ep0_req & ~eclr) | e[8:7];
    if (w && a == 4'd0) m_bus_en = d[6:0];
    if (w && a == 4'd2) m_ep0_en = d[1:0];
    @(negedge clk);
    chk(irq == m_any(), {tag, " irq R5"}, irq, m_any());
    chk(vec == (m_any() ? m_vec() : m_last), {tag, " vec R6"}, vec, m_any() ? m_vec() : m_last);
    chk(rdata == m_read(a), {tag, " read R9"}, rdata, m_read(a));
    chk(vec != 12'h51C, {tag, " reserved R7"}, vec, 12'h51C);
  endtask

  task automatic idle(input logic [3:0] a, input string tag);
    cycle(9'd0, 1'b0, a, 8'd0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd20240611);
    m_bus_en = '0; m_bus_req = '0; m_ep0_en = '0; m_ep0_req = '0; m_last = 12'h500;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      addr = 4'(a);
      #0.1;
      chk(rdata == 8'h00, "R1 register zero", rdata, 0);
    end
    chk(irq == 1'b0, "R1 irq low", irq, 0);
    chk(vec == 12'h500, "R1 vector base", vec, 12'h500);

    // R2: disabled source still latches, no interrupt
    cycle(9'h001, 1'b0, 4'd1, 8'd0, "R2");
    chk(rdata == 8'h01, "R2 latched while disabled", rdata, 8'h01);
    chk(irq == 1'b0, "R2 no irq when disabled", irq, 0);

    // R10 / R9: enable write, bit7 reads 0
    cycle(9'h000, 1'b1, 4'd0, 8'hFF, "R10");
    chk(rdata == 8'h7F, "R10 enable readback", rdata, 8'h7F);
    chk(irq == 1'b1, "R5 irq once enabled", irq, 1);
    chk(vec == 12'h500, "R6 setup data slot", vec, 12'h500);

    // R3: write zero keeps, write one clears
    cycle(9'h000, 1'b1, 4'd1, 8'h00, "R3");
    chk(rdata == 8'h01, "R3 zero write keeps", rdata, 8'h01);
    cycle(9'h000, 1'b1, 4'd1, 8'h01, "R3");
    chk(rdata == 8'h00, "R3 one write clears", rdata, 0);
    chk(irq == 1'b0, "R5 irq drops", irq, 0);
    chk(vec == 12'h500, "R8 vector held", vec, 12'h500);

    // R6: suspend beats control ACK
    cycle(9'h048, 1'b0, 4'd1, 8'd0, "R6");
    chk(vec == 12'h50C, "R6 suspend slot", vec, 12'h50C);
    cycle(9'h000, 1'b1, 4'd1, 8'h08, "R6");
    chk(vec == 12'h518, "R6 control ACK slot", vec, 12'h518);
    cycle(9'h000, 1'b1, 4'd1, 8'h40, "R8");
    chk(vec == 12'h518, "R8 hold after clear", vec, 12'h518);

    // R7: endpoint-zero slots skip the reserved code
    cycle(9'h000, 1'b1, 4'd2, 8'hFF, "R10");
    chk(rdata == 8'h03, "R9 ep0 enable width", rdata, 8'h03);
    cycle(9'h180, 1'b0, 4'd3, 8'd0, "R7");
    chk(vec == 12'h520, "R7 EP0-IN vector", vec, 12'h520);
    cycle(9'h000, 1'b1, 4'd3, 8'h01, "R7");
    chk(vec == 12'h524, "R7 EP0-OUT vector", vec, 12'h524);
    cycle(9'h000, 1'b1, 4'd3, 8'h02, "R8");
    chk(vec == 12'h524, "R8 hold after ep0 clear", vec, 12'h524);
    chk(irq == 1'b0, "R5 irq low after ep0 clear", irq, 0);

    // R4: set wins over a same-cycle clear
    cycle(9'h002, 1'b0, 4'd1, 8'd0, "R4");
    cycle(9'h002, 1'b1, 4'd1, 8'h02, "R4");
    chk(rdata == 8'h02, "R4 set beats clear", rdata, 8'h02);
    cycle(9'h100, 1'b1, 4'd3, 8'h02, "R4");
    chk(rdata == 8'h02, "R4 set beats clear ep0", rdata, 8'h02);

    // R9: unmapped address ignores writes, reads zero
    cycle(9'h000, 1'b1, 4'd9, 8'hFF, "R9");
    chk(rdata == 8'h00, "R9 unmapped reads zero", rdata, 0);
    idle(4'd0, "R9");
    chk(rdata == 8'h7F, "R9 enables untouched", rdata, 8'h7F);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [8:0] e;
      logic       w;
      logic [3:0] a;
      logic [7:0] d;
      e = 9'($urandom & $urandom & $urandom);
      w = ($urandom % 3) == 0;
      a = (($urandom % 8) == 0) ? 4'($urandom) : 4'($urandom % 4);
      d = 8'($urandom);
      if (a == 4'd0 || a == 4'd2) d = d & 8'($urandom);
      cycle(e, w, a, d, "rand");
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule